// File: doc/BRIEF.md
# I2C Target with Persistent Register Pointer

This block is the serial front end of a small sensor-style register file. It watches an oversampled I2C clock and data line and detects START and STOP conditions. It answers one 7-bit target address. The upper four bits of that address are fixed and the lower three come from strap pins. It acknowledges by enabling an open-drain pull-down on SDA.

A write transaction always stores its first data byte as the register pointer. Bytes after that are gathered into 16-bit words, most significant byte first. Each completed word leaves the block as a single-cycle write strobe addressed by the pointer. A read transaction returns the word at the pointer, high byte then low byte. Read data is taken from a plain input that the register file drives combinationally from the pointer output. The pointer stays the same between transactions, so a controller can read the same register again and again without sending it each time.

The write strobe has no back-pressure. I2C offers no way to hold off the controller here, because clock stretching is not part of this design. The consumer must therefore accept `wr_valid_o` in the cycle it is high. There is no ready signal, and address and data are valid only in that cycle.

Top module: `i2c_ptr_target`

## Requirements
- R1: The target address is binary 1001 in bits 6..3 followed by `strap_i[2:0]` in bits 2..0 (0x48 to 0x4F). For a matching address byte, whose bit 0 is the direction (0 write, 1 read), SDA is pulled low through the ninth SCL clock.
- R2: A START (SDA falling while SCL is high) begins a new address phase from any state, including the middle of a byte. A STOP (SDA rising while SCL is high) returns the target to idle. A byte cut short by a START does not change the pointer.
- R3: After a non-matching address the target does not acknowledge, never drives SDA and issues no write strobe until the next START or STOP. The pointer is left unchanged.
- R4: In a write, the first byte after the address is acknowledged and stored as the pointer, which appears on `reg_addr_o`.
- R5: Later bytes of a write are each acknowledged and taken in pairs, the first as bits 15..8. Each pair gives one strobe with `reg_addr_o` equal to the pointer. A trailing unpaired byte is dropped.
- R6: A read returns the word at the most recently written pointer, bits 15..8 first and each byte MSB first. This also holds in a later transaction, or after a repeated START that follows the pointer write.
- R7: If the controller acknowledges the low byte, the high byte of the same register is sent again. The word is sampled afresh, and the pointer does not advance.
- R8: After the controller gives a not-acknowledge, SDA stays released until the next START or STOP.
- R9: The SDA enable changes only while SCL is low. It is released on the SCL falling edge that ends an acknowledge, and it is low out of reset.
- R10: `wr_valid_o` is high for exactly one clock per completed word and is low out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw I2C clock line level |
| sda_i | input | 1 | Raw I2C data line level |
| strap_i | input | 3 | Low address bits from strap pins |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr_o | output | 8 | Current pointer, register address for read and write |
| wr_valid_o | output | 1 | One-cycle write strobe, no back-pressure |
| wr_data_o | output | 16 | Word to write, valid with the strobe |
| rd_data_i | input | 16 | Word at `reg_addr_o`, driven by the register file |

## Verification
The in-RTL assertions check four rules on every clock: the SDA enable stays steady while the synchronised SCL is high, an acknowledge is driven only for a matching address, SDA stays released in the ignore state and in the controller's acknowledge slot, and each write strobe lasts one clock. The bench scenarios are what show the byte-level protocol. These cover the pointer persisting across transactions and repeated STARTs, the MSB-first word order, the repeated high byte after an acknowledged low byte, dropped odd bytes, silence after a foreign address, and a START that cuts a byte short.

// File: rtl/i2c_ptr_pkg.sv
package i2c_ptr_pkg;
  // Bus-side protocol states of the target.
  typedef enum logic [2:0] {
    ST_IDLE, // bus free or not yet addressed
    ST_ADDR, // shifting the address byte
    ST_AACK, // driving the address acknowledge
    ST_RX,   // shifting a write byte
    ST_RACK, // driving a write-byte acknowledge
    ST_TX,   // presenting read bits
    ST_TACK, // controller acknowledge slot
    ST_IGN   // off the bus until START/STOP
  } st_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_ptr_sync.sv
module i2c_ptr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= '1;
    end else begin
      chain <= {chain[STAGES-2:0], d_i};
      prev  <= chain[STAGES-1];
    end
  end

  assign q_o    = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev;
  assign fall_o = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2c_ptr_cond.sv
module i2c_ptr_cond (
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  // Data may only move while the clock is low; a move with SCL high frames a transfer.
  assign start_o = scl_lvl_i & sda_fall_i;
  assign stop_o  = scl_lvl_i & sda_rise_i;
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
  import i2c_ptr_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR   = 7'h48,
  parameter int         STRAP_W     = 3,
  parameter int         REG_W       = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  reg_addr_o,
  output logic               wr_valid_o,
  output logic [REG_W-1:0]   wr_data_o,
  input  logic [REG_W-1:0]   rd_data_i
);
  localparam int NBYTE  = REG_W / BYTE_W;
  localparam int BIDX_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;
  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(NBYTE - 1);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  logic [1:0] lvl, rise, fall;
  logic       scl_q, sda_q, scl_rise, scl_fall, start, stop;

  i2c_ptr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}),
    .q_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  i2c_ptr_cond u_cond (
    .scl_lvl_i(lvl[1]), .sda_rise_i(rise[0]), .sda_fall_i(fall[0]),
    .start_o(start), .stop_o(stop)
  );

  assign scl_q    = lvl[1];
  assign sda_q    = lvl[0];
  assign scl_rise = rise[1];
  assign scl_fall = fall[1];

  st_e                st;
  logic [3:0]         cnt;
  logic [BYTE_W-1:0]  sh, ptr_q;
  logic               rw_q, ptr_phase, nack_q, oe_q, wv_q;
  logic [REG_W-1:0]   tx_q, wbuf_q, wdat_q;
  logic [BIDX_W-1:0]  bidx;
  logic               addr_hit;

  assign addr_hit = (sh[7:1] == {BASE_ADDR[6:STRAP_W], strap_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; ptr_q <= '0;
      rw_q <= 1'b0; ptr_phase <= 1'b0; nack_q <= 1'b0; oe_q <= 1'b0; wv_q <= 1'b0;
      tx_q <= '0; wbuf_q <= '0; wdat_q <= '0; bidx <= '0;
    end else begin
      wv_q <= 1'b0;
      if (start) begin
        st <= ST_ADDR; cnt <= '0; oe_q <= 1'b0;
      end else if (stop) begin
        st <= ST_IDLE; oe_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  oe_q <= 1'b1; rw_q <= sh[0]; st <= ST_AACK;
                end else begin
                  st <= ST_IGN;
                end
              end else begin
                oe_q <= 1'b1; st <= ST_RACK;
                if (ptr_phase) begin
                  ptr_q <= sh; ptr_phase <= 1'b0; bidx <= '0;
                end else begin
                  wbuf_q <= {wbuf_q[REG_W-BYTE_W-1:0], sh};
                  if (bidx == LAST_BYTE) begin
                    wdat_q <= {wbuf_q[REG_W-BYTE_W-1:0], sh};
                    wv_q   <= 1'b1;
                    bidx   <= '0;
                  end else begin
                    bidx <= bidx + 1'b1;
                  end
                end
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            if (rw_q) begin
              oe_q <= ~rd_data_i[REG_W-1];
              tx_q <= rd_data_i << 1;
              bidx <= '0; cnt <= 4'd1; st <= ST_TX;
            end else begin
              oe_q <= 1'b0; ptr_phase <= 1'b1; cnt <= '0; st <= ST_RX;
            end
          end
          ST_RACK: if (scl_fall) begin
            oe_q <= 1'b0; st <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (cnt == FULL) begin
              oe_q <= 1'b0; st <= ST_TACK;
            end else begin
              oe_q <= ~tx_q[REG_W-1];
              tx_q <= tx_q << 1;
              cnt  <= cnt + 4'd1;
            end
          end
          ST_TACK: begin
            if (scl_rise) nack_q <= sda_q;
            else if (scl_fall) begin
              if (nack_q) begin
                st <= ST_IGN;
              end else if (bidx == LAST_BYTE) begin
                oe_q <= ~rd_data_i[REG_W-1];
                tx_q <= rd_data_i << 1;
                bidx <= '0; cnt <= 4'd1; st <= ST_TX;
              end else begin
                oe_q <= ~tx_q[REG_W-1];
                tx_q <= tx_q << 1;
                bidx <= bidx + 1'b1; cnt <= 4'd1; st <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign reg_addr_o = ptr_q;
  assign wr_valid_o = wv_q;
  assign wr_data_o  = wdat_q;

  // SDA must never move under a high clock, or the controller sees START/STOP.
  assert_sda_quiet_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q)) |-> $stable(sda_oe_o));

  assert_ack_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> addr_hit);

  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe_o);

  assert_ctrl_ack_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TACK) |-> !sda_oe_o);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
endmodule

// File: tb/i2c_ptr_target_test.sv
`timescale 1ns/1ps
module i2c_ptr_target_test;
  localparam int Q = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sda_oe_o, wr_valid_o;
  logic [7:0]  reg_addr_o;
  logic [15:0] wr_data_o, rd_data_i;
  wire         sda_bus = sda_m & ~sda_oe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_ptr_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o), .wr_valid_o(wr_valid_o),
    .wr_data_o(wr_data_o), .rd_data_i(rd_data_i)
  );

  // Register file model: unwritten registers read {addr, ~addr}.
  logic [15:0]  mem [256];
  logic [255:0] written;
  always @(posedge clk) begin
    if (!rst_n) written <= '0;
    else if (wr_valid_o) begin
      mem[reg_addr_o]     <= wr_data_o;
      written[reg_addr_o] <= 1'b1;
    end
  end
  assign rd_data_i = written[reg_addr_o] ? mem[reg_addr_o] : {reg_addr_o, ~reg_addr_o};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard of expected write strobes {addr, data}.
  logic [23:0] exp_q [$];
  logic        prev_wv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid_o) begin
        chk(!prev_wv, "R10", "strobe width", 2, 1);
        if (exp_q.size() == 0)
          chk(1'b0, "R3", "unexpected write", int'({reg_addr_o, wr_data_o}), 0);
        else begin
          logic [23:0] it;
          it = exp_q.pop_front();
          chk({reg_addr_o, wr_data_o} == it, "R5", "write strobe",
              int'({reg_addr_o, wr_data_o}), int'(it));
        end
      end
      prev_wv = wr_valid_o;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; wait_q(); scl = 1'b1; wait_q();
    s = sda_bus; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    logic [7:0] echo;
    for (int i = 7; i >= 0; i--) begin bus_bit(b[i], s); echo[i] = s; end
    bus_bit(1'b1, s);
    chk(echo == b, "R9", "bus not driven during data bits", echo, b);
    chk((!s) == exp_ack, req, "acknowledge", int'(!s), int'(exp_ack));
  endtask

  task automatic get_byte(input bit ack, input logic [7:0] exp, input string req);
    logic s;
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); d[i] = s; end
    bus_bit(!ack, s);
    chk(d == exp, req, "read byte", d, exp);
  endtask

  initial begin
    logic s;
    repeat (5) @(negedge clk);
    chk(sda_oe_o == 1'b0, "R9", "reset SDA enable", sda_oe_o, 0);
    chk(wr_valid_o == 1'b0, "R10", "reset strobe", wr_valid_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4/R5: pointer, one word, trailing odd byte dropped
    bus_start();
    put_byte(8'h9A, 1'b1, "R1");
    put_byte(8'h12, 1'b1, "R4");
    exp_q.push_back(24'h12ABCD);
    put_byte(8'hAB, 1'b1, "R5");
    put_byte(8'hCD, 1'b1, "R5");
    put_byte(8'hEF, 1'b1, "R5");
    bus_stop();
    chk(reg_addr_o == 8'h12, "R4", "pointer", reg_addr_o, 8'h12);

    // R6: read in a new transaction, pointer reused
    bus_start();
    put_byte(8'h9B, 1'b1, "R1");
    get_byte(1'b1, 8'hAB, "R6");
    get_byte(1'b0, 8'hCD, "R6");
    bus_stop();

    // R5: two words to the same register, no increment
    bus_start();
    put_byte(8'h9A, 1'b1, "R1");
    put_byte(8'h07, 1'b1, "R4");
    exp_q.push_back(24'h071234);
    exp_q.push_back(24'h075678);
    put_byte(8'h12, 1'b1, "R5");
    put_byte(8'h34, 1'b1, "R5");
    put_byte(8'h56, 1'b1, "R5");
    put_byte(8'h78, 1'b1, "R5");
    bus_stop();

    // R6/R7/R8: pointer write, repeated START, read with wraparound, then NACK
    bus_start();
    put_byte(8'h9A, 1'b1, "R1");
    put_byte(8'h12, 1'b1, "R4");
    bus_start();
    put_byte(8'h9B, 1'b1, "R6");
    get_byte(1'b1, 8'hAB, "R6");
    get_byte(1'b1, 8'hCD, "R6");
    get_byte(1'b0, 8'hAB, "R7");
    get_byte(1'b0, 8'hFF, "R8");
    bus_stop();

    // R3: foreign address 0x48 while strapped to 0x4D
    bus_start();
    put_byte(8'h90, 1'b0, "R3");
    put_byte(8'h07, 1'b0, "R3");
    put_byte(8'h55, 1'b0, "R3");
    put_byte(8'h66, 1'b0, "R3");
    bus_stop();
    chk(reg_addr_o == 8'h12, "R3", "pointer untouched", reg_addr_o, 8'h12);

    // R1: new strap value, unwritten register default
    strap = 3'b000;
    bus_start();
    put_byte(8'h90, 1'b1, "R1");
    put_byte(8'h3C, 1'b1, "R4");
    bus_start();
    put_byte(8'h91, 1'b1, "R1");
    get_byte(1'b1, 8'h3C, "R6");
    get_byte(1'b0, 8'hC3, "R6");
    bus_stop();

    // R2: START in the middle of a pointer byte
    bus_start();
    put_byte(8'h90, 1'b1, "R1");
    for (int i = 0; i < 4; i++) bus_bit(1'b1, s);
    bus_start();
    put_byte(8'h91, 1'b1, "R2");
    get_byte(1'b1, 8'h3C, "R2");
    get_byte(1'b0, 8'hC3, "R2");
    bus_stop();
    chk(reg_addr_o == 8'h3C, "R2", "pointer after cut byte", reg_addr_o, 8'h3C);

    // R5/R2: STOP after an odd data byte, then read the last full word
    bus_start();
    put_byte(8'h90, 1'b1, "R1");
    put_byte(8'h07, 1'b1, "R4");
    put_byte(8'h99, 1'b1, "R5");
    bus_stop();
    bus_start();
    put_byte(8'h91, 1'b1, "R1");
    get_byte(1'b1, 8'h56, "R5");
    get_byte(1'b0, 8'h78, "R5");
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "writes still pending", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule